// File: doc/BRIEF.md
# PS/2 Host Receive Engine

This block receives the serial frames that a PS/2 keyboard or mouse sends towards the host and turns each frame into a byte that a processor can read. The open-collector clock and data lines from the pad come in asynchronous to the system clock. Each line passes through a two-stage synchronizer and a majority-free glitch filter. After that, falling edges of the device clock are detected and one frame bit is taken at each such edge.

A frame is checked for a low start bit, a high stop bit and odd parity. Only when all three checks hold is the byte placed on the data output and an interrupt pulse of fixed minimum length raised. The processor reads the byte whenever it likes, with no handshake. The byte stays put until another good frame replaces it.

A busy flag marks a frame in progress. A companion transmitter can assert an inhibit request, which abandons any partial frame at once. A timeout counted in reference-clock ticks drops a frame that the device leaves unfinished.

Top module: `ps2_rx_engine`

## Requirements
- R1: A frame is eleven bits, each sampled at a falling edge of the filtered device clock: start, eight data bits least significant first, parity, stop. A good frame places its data bits on `rx_byte_o`, with the first data bit in bit 0.
- R2: Parity is odd over data and parity bit together: the parity bit is 1 exactly when the data byte holds an even number of ones. A frame with wrong parity leaves `rx_byte_o` unchanged and raises no interrupt.
- R3: A frame whose start bit is 1 or whose stop bit is 0 is discarded. `rx_byte_o` is unchanged and no interrupt is raised.
- R4: For each good frame, `rx_irq_o` rises once and stays high for exactly `IRQ_CYCLES` system clock cycles. `IRQ_CYCLES` defaults to 13 and must be at least 13. `rx_byte_o` changes only for a good frame and then holds its value without any read handshake.
- R5: `busy_o` goes high from the first falling clock edge of a frame until the frame ends, is discarded or is aborted. It is low when idle.
- R6: While `inhibit_i` is high, reception is halted and `busy_o` is low one cycle later. Any partial frame is dropped and the bit count restarts. A frame clocked in while inhibit is held produces no byte and no interrupt.
- R7: If `TIMEOUT_TICKS` pulses of `tick_i` pass during a frame with no falling clock edge, the partial frame is dropped and the block returns to idle. The next frame is then received from its start bit.
- R8: A level on either PS/2 line lasting fewer than `FILT_LEN` system cycles is ignored, so a short low glitch on the clock line while idle starts no frame.
- R9: After reset, `rx_byte_o` is 0x00 and `rx_irq_o` and `busy_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | One-cycle pulse at the 1 MHz reference rate, used for the timeout |
| ps2_clk_i | input | 1 | PS/2 clock line as seen at the pad, asynchronous |
| ps2_dat_i | input | 1 | PS/2 data line as seen at the pad, asynchronous |
| inhibit_i | input | 1 | Receive-inhibit request from the transmitter |
| rx_byte_o | output | 8 | Last correctly received byte |
| rx_irq_o | output | 1 | Stretched pulse for each good frame |
| busy_o | output | 1 | High while a frame is being received |

## Verification
The assertions assume that `inhibit_i` and the PS/2 lines behave as a real device and transmitter would. In particular, they assume that a new good frame cannot complete within a single cycle of the previous one, since a frame needs eleven filtered clock edges. The bench device model always holds each clock phase for many more system cycles than `FILT_LEN`. It changes data only while the clock is high, and it changes all inputs on the falling system clock edge. Its glitches are kept shorter than the filter length, so every edge it means to be seen is seen exactly once.

// File: rtl/ps2_rx_pkg.sv
package ps2_rx_pkg;

    localparam int FRAME_BITS = 11;
    localparam int CNT_W      = $clog2(FRAME_BITS);

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RECV = 1'b1
    } rx_state_e;

    // odd parity over data plus parity bit means an odd total count of ones
    function automatic logic parity_ok(input logic [7:0] data, input logic par);
        return ^{data, par};
    endfunction

endpackage

// File: rtl/ps2_rx_sync.sv
module ps2_rx_sync #(
    parameter int   FILT_LEN = 4,
    parameter logic RST_VAL  = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic line_i,
    output logic line_o
);

    typedef struct packed {
        logic                meta;
        logic                sync;
        logic [FILT_LEN-1:0] hist;
        logic                level;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.meta = line_i;
        s_d.sync = s_q.meta;
        s_d.hist = {s_q.hist[FILT_LEN-2:0], s_q.sync};
        if (&s_q.hist) begin
            s_d.level = 1'b1;
        end else if (~|s_q.hist) begin
            s_d.level = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '{meta: RST_VAL, sync: RST_VAL, hist: {FILT_LEN{RST_VAL}}, level: RST_VAL};
        end else begin
            s_q <= s_d;
        end
    end

    assign line_o = s_q.level;

endmodule

// File: rtl/ps2_rx_frame.sv
module ps2_rx_frame
    import ps2_rx_pkg::*;
#(
    parameter int TIMEOUT_TICKS = 2000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_i,
    input  logic       inhibit_i,
    input  logic       line_clk_i,
    input  logic       line_dat_i,
    output logic [7:0] byte_o,
    output logic       done_o,
    output logic       busy_o
);

    localparam int TOUT_W = $clog2(TIMEOUT_TICKS + 1);
    localparam logic [CNT_W-1:0]  LAST_BIT  = CNT_W'(FRAME_BITS - 1);
    localparam logic [TOUT_W-1:0] TOUT_LAST = TOUT_W'(TIMEOUT_TICKS - 1);

    typedef struct packed {
        rx_state_e         st;
        logic              clk_prev;
        logic [CNT_W-1:0]  cnt;
        logic [9:0]        sh;
        logic              start_bad;
        logic [TOUT_W-1:0] tout;
        logic [7:0]        data;
        logic              done;
    } frame_t;

    frame_t f_d, f_q;
    logic       fall;
    logic [9:0] sh_n;

    always_comb begin
        f_d          = f_q;
        f_d.done     = 1'b0;
        f_d.clk_prev = line_clk_i;
        fall         = f_q.clk_prev & ~line_clk_i;
        sh_n         = {line_dat_i, f_q.sh[9:1]};

        if (inhibit_i) begin
            f_d.st   = ST_IDLE;
            f_d.cnt  = '0;
            f_d.tout = '0;
        end else begin
            case (f_q.st)
                ST_IDLE: begin
                    if (fall) begin
                        f_d.st        = ST_RECV;
                        f_d.cnt       = CNT_W'(1);
                        f_d.start_bad = line_dat_i;
                        f_d.tout      = '0;
                    end
                end
                ST_RECV: begin
                    if (fall) begin
                        f_d.sh   = sh_n;
                        f_d.tout = '0;
                        if (f_q.cnt == LAST_BIT) begin
                            f_d.st  = ST_IDLE;
                            f_d.cnt = '0;
                            if (!f_q.start_bad && sh_n[9] && parity_ok(sh_n[7:0], sh_n[8])) begin
                                f_d.data = sh_n[7:0];
                                f_d.done = 1'b1;
                            end
                        end else begin
                            f_d.cnt = f_q.cnt + CNT_W'(1);
                        end
                    end else if (tick_i) begin
                        if (f_q.tout == TOUT_LAST) begin
                            f_d.st   = ST_IDLE;
                            f_d.cnt  = '0;
                            f_d.tout = '0;
                        end else begin
                            f_d.tout = f_q.tout + TOUT_W'(1);
                        end
                    end
                end
                default: f_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            f_q <= '{st: ST_IDLE, clk_prev: 1'b1, cnt: '0, sh: '0, start_bad: 1'b0,
                     tout: '0, data: '0, done: 1'b0};
        end else begin
            f_q <= f_d;
        end
    end

    assign byte_o = f_q.data;
    assign done_o = f_q.done;
    assign busy_o = (f_q.st == ST_RECV);

endmodule

// File: rtl/ps2_rx_irq.sv
module ps2_rx_irq #(
    parameter int IRQ_CYCLES = 13
) (
    input  logic clk,
    input  logic rst,
    input  logic done_i,
    output logic irq_o
);

    localparam int IRQ_W = $clog2(IRQ_CYCLES + 1);

    typedef struct packed {
        logic [IRQ_W-1:0] left;
    } irq_t;

    irq_t i_d, i_q;

    always_comb begin
        i_d = i_q;
        if (done_i) begin
            i_d.left = IRQ_W'(IRQ_CYCLES);
        end else if (i_q.left != '0) begin
            i_d.left = i_q.left - IRQ_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            i_q <= '{left: '0};
        end else begin
            i_q <= i_d;
        end
    end

    assign irq_o = (i_q.left != '0);

endmodule

// File: rtl/ps2_rx_engine.sv
module ps2_rx_engine #(
    parameter int FILT_LEN      = 4,
    parameter int TIMEOUT_TICKS = 2000,
    parameter int IRQ_CYCLES    = 13
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_i,
    input  logic       ps2_clk_i,
    input  logic       ps2_dat_i,
    input  logic       inhibit_i,
    output logic [7:0] rx_byte_o,
    output logic       rx_irq_o,
    output logic       busy_o
);

    localparam int NUM_LINES = 2;

    logic [NUM_LINES-1:0] raw_lines;
    logic [NUM_LINES-1:0] clean_lines;
    logic                 frame_done;

    assign raw_lines = {ps2_dat_i, ps2_clk_i};

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        ps2_rx_sync #(
            .FILT_LEN (FILT_LEN),
            .RST_VAL  (1'b1)
        ) u_sync (
            .clk    (clk),
            .rst    (rst),
            .line_i (raw_lines[g]),
            .line_o (clean_lines[g])
        );
    end

    ps2_rx_frame #(
        .TIMEOUT_TICKS (TIMEOUT_TICKS)
    ) u_frame (
        .clk        (clk),
        .rst        (rst),
        .tick_i     (tick_i),
        .inhibit_i  (inhibit_i),
        .line_clk_i (clean_lines[0]),
        .line_dat_i (clean_lines[1]),
        .byte_o     (rx_byte_o),
        .done_o     (frame_done),
        .busy_o     (busy_o)
    );

    ps2_rx_irq #(
        .IRQ_CYCLES (IRQ_CYCLES)
    ) u_irq (
        .clk    (clk),
        .rst    (rst),
        .done_i (frame_done),
        .irq_o  (rx_irq_o)
    );

endmodule

// File: rtl/ps2_rx_engine_chk.sv
module ps2_rx_engine_chk #(
    parameter int IRQ_CYCLES = 13
) (
    input logic       clk,
    input logic       rst,
    input logic       inhibit_i,
    input logic [7:0] rx_byte_o,
    input logic       rx_irq_o,
    input logic       busy_o
);

    localparam int HW = $clog2(IRQ_CYCLES + 2) + 1;

    logic [HW-1:0] hi_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_cnt <= '0;
        end else if (rx_irq_o) begin
            hi_cnt <= hi_cnt + HW'(1);
        end else begin
            hi_cnt <= '0;
        end
    end

    // R4: pulse never shorter than the configured length
    assert_irq_width_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(rx_irq_o) |-> (hi_cnt >= HW'(IRQ_CYCLES)));

    // R4: output byte only moves when a good frame is reported
    assert_byte_only_on_irq_R4: assert property (@(posedge clk) disable iff (rst)
        !$stable(rx_byte_o) |=> $rose(rx_irq_o));

    // R5: interrupt is reported after the frame has ended
    assert_irq_after_frame_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_irq_o) |-> !busy_o);

    // R6: inhibit halts reception on the next cycle
    assert_inhibit_halts_R6: assert property (@(posedge clk) disable iff (rst)
        inhibit_i |=> !busy_o);

    // R6: no frame may begin while inhibit is held
    assert_no_start_inhibited_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> !$past(inhibit_i));

endmodule

bind ps2_rx_engine ps2_rx_engine_chk #(
    .IRQ_CYCLES (IRQ_CYCLES)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .inhibit_i (inhibit_i),
    .rx_byte_o (rx_byte_o),
    .rx_irq_o  (rx_irq_o),
    .busy_o    (busy_o)
);

// File: tb/ps2_rx_engine_tb.sv
`timescale 1ns/1ps
module ps2_rx_engine_tb;

    localparam int FILT_LEN      = 4;
    localparam int TIMEOUT_TICKS = 50;
    localparam int IRQ_CYCLES    = 13;
    localparam int HALF          = 20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_i = 1'b0;
    logic       ps2_clk_i = 1'b1;
    logic       ps2_dat_i = 1'b1;
    logic       inhibit_i = 1'b0;
    logic [7:0] rx_byte_o;
    logic       rx_irq_o;
    logic       busy_o;

    int checks = 0;
    int errors = 0;
    int irq_count = 0;
    int irq_width = 0;
    int last_width = 0;
    logic irq_prev = 1'b0;
    logic [7:0] exp_byte = 8'h00;

    always #2 clk = ~clk;

    ps2_rx_engine #(
        .FILT_LEN      (FILT_LEN),
        .TIMEOUT_TICKS (TIMEOUT_TICKS),
        .IRQ_CYCLES    (IRQ_CYCLES)
    ) u_dut (
        .clk       (clk),
        .rst       (rst),
        .tick_i    (tick_i),
        .ps2_clk_i (ps2_clk_i),
        .ps2_dat_i (ps2_dat_i),
        .inhibit_i (inhibit_i),
        .rx_byte_o (rx_byte_o),
        .rx_irq_o  (rx_irq_o),
        .busy_o    (busy_o)
    );

    // reference tick every 4 system cycles
    int tick_div = 0;
    always @(negedge clk) begin
        tick_div <= (tick_div == 3) ? 0 : tick_div + 1;
        tick_i   <= (tick_div == 3);
    end

    // interrupt monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rx_irq_o && !irq_prev) irq_count <= irq_count + 1;
        if (rx_irq_o) irq_width <= irq_width + 1;
        else begin
            if (irq_prev) last_width <= irq_width;
            irq_width <= 0;
        end
        irq_prev <= rx_irq_o;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors = errors + 1;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    function automatic logic odd_par(input logic [7:0] b);
        return ~^b;
    endfunction

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // device model: kind 0 good, 1 bad parity, 2 bad start, 3 bad stop
    task automatic send_frame(input logic [7:0] b, input int kind, input int nbits);
        logic [10:0] fr;
        fr = {1'b1, odd_par(b), b, 1'b0};
        if (kind == 1) fr[9]  = ~fr[9];
        if (kind == 2) fr[0]  = 1'b1;
        if (kind == 3) fr[10] = 1'b0;
        for (int i = 0; i < nbits; i++) begin
            @(negedge clk);
            ps2_dat_i = fr[i];
            wait_cyc(HALF);
            ps2_clk_i = 1'b0;
            wait_cyc(HALF);
            ps2_clk_i = 1'b1;
        end
        @(negedge clk);
        ps2_dat_i = 1'b1;
    endtask

    task automatic frame_and_check(input logic [7:0] b, input int kind, input string tag);
        int irq0;
        irq0 = irq_count;
        send_frame(b, kind, 11);
        wait_cyc(2 * HALF);
        if (kind == 0) begin
            exp_byte = b;
            check(irq_count == irq0 + 1, {tag, " irq count"}, irq_count - irq0, 1);
            check(last_width == IRQ_CYCLES, "R4 irq width", last_width, IRQ_CYCLES);
        end else begin
            check(irq_count == irq0, {tag, " no irq"}, irq_count - irq0, 0);
        end
        check(rx_byte_o == exp_byte, {tag, " byte"}, rx_byte_o, exp_byte);
        check(busy_o == 1'b0, "R5 idle after frame", busy_o, 0);
    endtask

    initial begin
        int irq0;
        void'($urandom(32'h5A17));
        wait_cyc(5);
        rst = 1'b0;
        wait_cyc(2);
        // R9 reset state
        check(rx_byte_o == 8'h00, "R9 byte", rx_byte_o, 0);
        check(rx_irq_o == 1'b0, "R9 irq", rx_irq_o, 0);
        check(busy_o == 1'b0, "R9 busy", busy_o, 0);

        // R1 directed patterns, LSB first
        frame_and_check(8'hA5, 0, "R1");
        frame_and_check(8'h01, 0, "R1");
        frame_and_check(8'h80, 0, "R1");
        frame_and_check(8'h00, 0, "R1");
        frame_and_check(8'hFF, 0, "R1");
        // R2 wrong parity
        frame_and_check(8'h3C, 1, "R2");
        // R3 bad start and bad stop
        frame_and_check(8'h5A, 2, "R3 start");
        frame_and_check(8'h5A, 3, "R3 stop");

        // R5 busy mid-frame, R7 timeout drops it
        send_frame(8'h77, 0, 5);
        wait_cyc(HALF);
        check(busy_o == 1'b1, "R5 busy mid-frame", busy_o, 1);
        wait_cyc(TIMEOUT_TICKS * 4 + 40);
        check(busy_o == 1'b0, "R7 timeout idle", busy_o, 0);
        frame_and_check(8'h6B, 0, "R7 after timeout");

        // R6 inhibit aborts a partial frame
        send_frame(8'h11, 0, 6);
        wait_cyc(4);
        inhibit_i = 1'b1;
        wait_cyc(3);
        check(busy_o == 1'b0, "R6 abort", busy_o, 0);
        inhibit_i = 1'b0;
        frame_and_check(8'hC3, 0, "R6 after abort");

        // R6 frame clocked in while inhibit is held
        inhibit_i = 1'b1;
        irq0 = irq_count;
        send_frame(8'h99, 0, 11);
        wait_cyc(2 * HALF);
        check(irq_count == irq0, "R6 held no irq", irq_count - irq0, 0);
        check(rx_byte_o == exp_byte, "R6 held byte", rx_byte_o, exp_byte);
        inhibit_i = 1'b0;
        wait_cyc(4);

        // R8 short clock glitch while idle
        @(negedge clk);
        ps2_clk_i = 1'b0;
        wait_cyc(FILT_LEN - 2);
        ps2_clk_i = 1'b1;
        wait_cyc(20);
        check(busy_o == 1'b0, "R8 glitch ignored", busy_o, 0);
        frame_and_check(8'h4E, 0, "R8 after glitch");

        // random mix
        for (int n = 0; n < 30; n++) begin
            logic [7:0] b;
            int r, kind;
            b = 8'($urandom);
            r = $urandom % 10;
            kind = (r < 6) ? 0 : (r < 8) ? 1 : (r < 9) ? 2 : 3;
            frame_and_check(b, kind, (kind == 0) ? "R1 random" : (kind == 1) ? "R2 random" : "R3 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule